// File: doc/BRIEF.md
# Saturating Scalar Add/Sub/Abs Unit

A purely combinational scalar arithmetic unit for a fixed-point datapath. Two data-width operands and a three-bit operation code come in. Out come a clamped result, a sign-extended copy of it for a wider register file, and a one-cycle overflow strobe. The strobe goes high only when the operation had to clamp. It is meant to be collected into an architectural sticky flag outside this block.

The unit has five operations. Signed add and signed subtract clamp to the two's-complement range. Unsigned add clamps to all ones and unsigned subtract clamps to zero. Absolute value clamps the single unrepresentable case, the most negative input. All five share one adder of data width plus one bit. Operation codes with no assigned meaning give an all-zero output with the strobe low.

Top module: `sat_scalar_alu`

## Requirements
- R1: With code 0 the result is opA plus opB as signed integers. A sum above 0x7FFFFFFF gives 0x7FFFFFFF and a sum below -2^31 gives 0x80000000, and in both cases ovfStrobe is 1.
- R2: With code 1 the result is opA minus opB as signed integers. It is clamped to [0x80000000, 0x7FFFFFFF] in the same way, with ovfStrobe 1 whenever it clamps.
- R3: With code 2 the result is the unsigned sum of opA and opB. A sum larger than 2^32-1 gives 0xFFFFFFFF with ovfStrobe 1.
- R4: With code 3 the result is opA minus opB as unsigned integers. A negative difference gives 0 with ovfStrobe 1.
- R5: With code 4 the result is opA if opA is non-negative and minus opA if it is negative. The input 0x80000000 gives 0x7FFFFFFF with ovfStrobe 1.
- R6: resultWide always holds result in bits 31:0, with bit 31 of result copied into every bit from 63 down to 32. This holds for every code, the unsigned ones included.
- R7: ovfStrobe is 0 for any operation whose exact result fits its range.
- R8: Codes 5, 6 and 7 give result 0, resultWide 0 and ovfStrobe 0 for any operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand (minuend for subtraction, source for absolute value) |
| opB | input | 32 | Second operand (subtrahend for subtraction, unused by absolute value) |
| opSel | input | 3 | Operation code: 0 signed add, 1 signed sub, 2 unsigned add, 3 unsigned sub, 4 absolute value |
| result | output | 32 | Clamped result |
| resultWide | output | 64 | result sign-extended from bit 31 |
| ovfStrobe | output | 1 | High when the current operation clamped |

## Verification
A narrow copy of the unit is swept over every pair of operands and every code, so each signed and unsigned overflow boundary is hit exactly. A design that detected signed overflow from the carry instead of the sign bits would clamp ordinary negative sums there. The full-width copy is driven with every pair drawn from 0, 1, -1, the largest positive value, the most negative value and a mid-range pattern. This catches an absolute value that wraps 0x80000000 back to itself, an unsigned subtract that wraps instead of flooring at zero, and an unsigned result that is zero-extended instead of sign-extended. Random operands then cover the middle of the range, where a strobe raised without any clamping would show.

// File: rtl/sat_alu_pkg.sv
package sat_alu_pkg;

  typedef enum logic [2:0] {
    OP_SADD = 3'd0,
    OP_SSUB = 3'd1,
    OP_UADD = 3'd2,
    OP_USUB = 3'd3,
    OP_ABS  = 3'd4
  } sat_op_e;

  // strobes from decode to the datapath
  typedef struct packed {
    logic opValid;
    logic isSigned;
    logic isSub;
    logic isAbs;
  } sat_ctrl_t;

endpackage

// File: rtl/sat_alu_ctrl.sv
module sat_alu_ctrl
  import sat_alu_pkg::*;
(
  input  logic [2:0] opSel,
  output sat_ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    case (opSel)
      OP_SADD: begin ctrl.opValid = 1'b1; ctrl.isSigned = 1'b1; end
      OP_SSUB: begin ctrl.opValid = 1'b1; ctrl.isSigned = 1'b1; ctrl.isSub = 1'b1; end
      OP_UADD: begin ctrl.opValid = 1'b1; end
      OP_USUB: begin ctrl.opValid = 1'b1; ctrl.isSub = 1'b1; end
      OP_ABS:  begin ctrl.opValid = 1'b1; ctrl.isSigned = 1'b1; ctrl.isAbs = 1'b1; end
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    if (!ctrl.opValid)
      AST_IDLE_STROBES: assert (!ctrl.isSigned && !ctrl.isSub && !ctrl.isAbs) else $error("idle decode raised a strobe"); // R8
  end

endmodule

// File: rtl/sat_alu_dp.sv
module sat_alu_dp
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  sat_ctrl_t         ctrl,
  output logic [DATA_W-1:0] result,
  output logic              clampHit
);

  localparam logic [DATA_W-1:0] SIGNED_MAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SIGNED_MIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic              absNeg;
  logic              doSub;
  logic [DATA_W-1:0] lhs;
  logic [DATA_W-1:0] rhs;
  logic [DATA_W-1:0] rhsEff;
  logic [DATA_W:0]   sumExt;
  logic [DATA_W-1:0] rawSum;
  logic              carryOut;
  logic              signedOvf;

  // operand steering: absolute value of a negative input is computed as 0 - opA
  always_comb begin
    absNeg = ctrl.isAbs & opA[DATA_W-1];
    doSub  = ctrl.isSub | absNeg;
    lhs    = absNeg ? '0 : opA;
    if (ctrl.isAbs) rhs = absNeg ? opA : '0;
    else            rhs = opB;
    rhsEff = doSub ? ~rhs : rhs;
  end

  // one shared adder, one bit wider than the data
  always_comb begin
    sumExt    = {1'b0, lhs} + {1'b0, rhsEff} + {{DATA_W{1'b0}}, doSub};
    rawSum    = sumExt[DATA_W-1:0];
    carryOut  = sumExt[DATA_W];
    signedOvf = (lhs[DATA_W-1] == rhsEff[DATA_W-1]) && (rawSum[DATA_W-1] != lhs[DATA_W-1]);
  end

  // clamp selection
  always_comb begin
    result   = '0;
    clampHit = 1'b0;
    if (ctrl.opValid) begin
      if (ctrl.isSigned) begin
        clampHit = signedOvf;
        result   = signedOvf ? (lhs[DATA_W-1] ? SIGNED_MIN : SIGNED_MAX) : rawSum;
      end else if (ctrl.isSub) begin
        clampHit = ~carryOut;
        result   = carryOut ? rawSum : '0;
      end else begin
        clampHit = carryOut;
        result   = carryOut ? '1 : rawSum;
      end
    end
  end

  always_comb begin
    if (ctrl.opValid && ctrl.isSigned && !ctrl.isAbs && clampHit)
      AST_SIGNED_CLAMP_RAIL: assert (result == SIGNED_MAX || result == SIGNED_MIN) else $error("signed clamp off rail"); // R1
    if (ctrl.opValid && !ctrl.isSigned && !ctrl.isSub)
      AST_UADD_NO_WRAP: assert (result >= opA && result >= opB) else $error("unsigned add wrapped"); // R3
    if (ctrl.opValid && !ctrl.isSigned && ctrl.isSub)
      AST_USUB_NO_WRAP: assert (result <= opA) else $error("unsigned sub wrapped"); // R4
    if (ctrl.opValid && ctrl.isAbs)
      AST_ABS_NONNEG: assert (!result[DATA_W-1]) else $error("abs result negative"); // R5
  end

endmodule

// File: rtl/sat_scalar_alu.sv
module sat_scalar_alu
  import sat_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int WIDE_W = 64
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [2:0]        opSel,
  output logic [DATA_W-1:0] result,
  output logic [WIDE_W-1:0] resultWide,
  output logic              ovfStrobe
);

  localparam int EXT_W = WIDE_W - DATA_W;

  sat_ctrl_t ctrl;

  sat_alu_ctrl u_ctrl (
    .opSel (opSel),
    .ctrl  (ctrl)
  );

  sat_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .opA      (opA),
    .opB      (opB),
    .ctrl     (ctrl),
    .result   (result),
    .clampHit (ovfStrobe)
  );

  assign resultWide = {{EXT_W{result[DATA_W-1]}}, result};

  always_comb begin
    if (opSel > 3'd4)
      AST_UNUSED_QUIET: assert (result == '0 && !ovfStrobe) else $error("unused code produced output"); // R8
    if (opSel == 3'd4 && !opA[DATA_W-1])
      AST_ABS_PASS: assert (result == opA && !ovfStrobe) else $error("abs altered non-negative input"); // R5
  end

endmodule

// File: tb/test_sat_scalar_alu.sv
`timescale 1ns/1ps
module test_sat_scalar_alu;

  localparam int NW  = 6;
  localparam int NWW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] opA, opB;
  logic [2:0]  opSel;
  logic [31:0] result;
  logic [63:0] resultWide;
  logic        ovfStrobe;

  logic [NW-1:0]  nA, nB;
  logic [2:0]     nSel;
  logic [NW-1:0]  nRes;
  logic [NWW-1:0] nWide;
  logic           nOvf;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  sat_scalar_alu i_sat_scalar_alu (
    .opA(opA), .opB(opB), .opSel(opSel),
    .result(result), .resultWide(resultWide), .ovfStrobe(ovfStrobe)
  );

  sat_scalar_alu #(.DATA_W(NW), .WIDE_W(NWW)) i_sat_scalar_alu_narrow (
    .opA(nA), .opB(nB), .opSel(nSel),
    .result(nRes), .resultWide(nWide), .ovfStrobe(nOvf)
  );

  function automatic longint maskOf(input int w);
    return (longint'(1) << w) - 1;
  endfunction

  function automatic string tagFor(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R8";
    endcase
  endfunction

  // arithmetic reference on 64-bit integers
  task automatic refModel(input int w, input int op, input longint ua, input longint ub,
                          output longint res, output bit ov);
    longint sa, sb, t, smax, smin, umax;
    umax = maskOf(w);
    smax = (longint'(1) << (w-1)) - 1;
    smin = -(longint'(1) << (w-1));
    sa = (ua > smax) ? ua - (longint'(1) << w) : ua;
    sb = (ub > smax) ? ub - (longint'(1) << w) : ub;
    ov = 0;
    case (op)
      0, 1: begin
        t = (op == 0) ? sa + sb : sa - sb;
        if (t > smax) begin t = smax; ov = 1; end
        else if (t < smin) begin t = smin; ov = 1; end
      end
      2: begin t = ua + ub; if (t > umax) begin t = umax; ov = 1; end end
      3: begin t = ua - ub; if (t < 0) begin t = 0; ov = 1; end end
      4: begin
        t = (sa < 0) ? -sa : sa;
        if (t > smax) begin t = smax; ov = 1; end
      end
      default: t = 0;
    endcase
    res = t & umax;
  endtask

  task automatic checkVec(input int w, input int ww, input int op, input longint ua, input longint ub,
                          input longint gotRes, input longint gotWide, input bit gotOv);
    longint expRes, expWide;
    bit expOv;
    refModel(w, op, ua, ub, expRes, expOv);
    expWide = expRes;
    if ((expRes >> (w-1)) & 1) expWide = expRes | (maskOf(ww) & ~maskOf(w));
    if (op > 4) expWide = 0;
    checks += 3;
    if (gotRes != expRes) begin
      errors++;
      $display("FAIL %s w=%0d op=%0d a=%h b=%h result got %h exp %h", tagFor(op), w, op, ua, ub, gotRes, expRes);
    end
    if (gotOv != expOv) begin
      errors++;
      $display("FAIL %s w=%0d op=%0d a=%h b=%h strobe got %0d exp %0d",
               expOv ? tagFor(op) : "R7", w, op, ua, ub, gotOv, expOv);
    end
    if (gotWide != expWide) begin
      errors++;
      $display("FAIL R6 w=%0d op=%0d a=%h b=%h wide got %h exp %h", w, op, ua, ub, gotWide, expWide);
    end
  endtask

  task automatic apply32(input int op, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk); #1;
    opSel = op[2:0]; opA = a; opB = b;
    #1;
    checkVec(32, 64, op, longint'(a), longint'(b), longint'(result), longint'(resultWide), ovfStrobe);
  endtask

  task automatic applyNarrow(input int op, input int a, input int b);
    @(posedge clk); #1;
    nSel = op[2:0]; nA = a[NW-1:0]; nB = b[NW-1:0];
    #1;
    checkVec(NW, NWW, op, longint'(nA), longint'(nB), longint'(nRes), longint'(nWide), nOvf);
  endtask

  logic [31:0] edgeVals [6];

  initial begin
    #(100000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    opA = '0; opB = '0; opSel = '0;
    nA = '0; nB = '0; nSel = '0;
    edgeVals[0] = 32'h0000_0000; edgeVals[1] = 32'h0000_0001;
    edgeVals[2] = 32'hFFFF_FFFF; edgeVals[3] = 32'h7FFF_FFFF;
    edgeVals[4] = 32'h8000_0000; edgeVals[5] = 32'h1234_5678;
    repeat (4) @(posedge clk);
    #1;
    // idle state with zero operands: R1 and R7 give zero, no strobe
    checkVec(32, 64, 0, 0, 0, longint'(result), longint'(resultWide), ovfStrobe);
    rstN = 1'b1;

    // full-width corner pairs, every code (R1..R8)
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply32(op, edgeVals[i], edgeVals[j]);

    // named corners
    apply32(4, 32'h8000_0000, 32'h0);      // R5 most negative clamps
    apply32(4, 32'hFFFF_FFFE, 32'h0);      // R5 plain negation
    apply32(3, 32'h0000_0005, 32'h0000_0009); // R4 floor at zero
    apply32(2, 32'h8000_0000, 32'h8000_0000); // R3 carry out, R6 sign copy
    apply32(1, 32'h8000_0000, 32'h0000_0001); // R2 negative rail

    // random mid-range traffic (R7)
    for (int k = 0; k < 2000; k++)
      apply32(int'($urandom_range(0, 7)), $urandom, $urandom);

    // exhaustive narrow sweep
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < (1 << NW); a++)
        for (int b = 0; b < (1 << NW); b++)
          applyNarrow(op, a, b);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule